// File: doc/BRIEF.md
# Reference Clock Selection Controller

This block chooses which of two reference clocks feeds a clock-synthesis loop and drives the select line of the external reference multiplexer. It runs on an independent system clock. Each reference is sampled as an asynchronous signal. The block has only control and status pins: no data stream passes through it, so there is no valid/ready handshake and no back-pressure.

In manual mode the operator's select input picks the reference directly. In automatic mode a missing-edge detector watches the reference now in use. When that reference stops toggling, the controller moves to the other input once. It then waits until automatic mode is switched off and on again before it makes another move.

The block also has these outputs:
- a select acknowledge, which shows the reference actually in use;
- a bandwidth control, which an initialization input forces to the wide setting;
- a registered loss-of-lock flag;
- a one-cycle trigger for the loop's hitless-switching logic, raised when lock is lost around a reselection.

Top module: `refsw_ctrl`

## Requirements
- R1: A synchronous active-high reset sets `mux_sel` to 0 and clears `ref_fail`, `lol_flag` and `hitless_trig`. No automatic switch is permitted until `auto_en` has been sampled high after reset.
- R2: While `auto_en` is low, `mux_sel` equals the value of `man_sel` sampled at the previous clock edge.
- R3: On the first clock edge at which `auto_en` is seen high (after reset or after it was low), `mux_sel` is loaded from `man_sel` and one automatic switch is permitted.
- R4: `sel_ack` always equals `mux_sel`, the reference really in use (0 or 1). After an automatic switch it may differ from `man_sel`.
- R5: Each reference passes through a two-flop synchronizer. `ref_fail` goes high when no rising edge of the active synchronized reference has been seen for FAIL_CYC (default 8) system-clock cycles. It drops one cycle after such an edge is seen.
- R6: In automatic mode with the permit held, a high `ref_fail` at a clock edge toggles `mux_sel` at that edge and consumes the permit.
- R7: Switching is non-revertive. After one automatic switch, `mux_sel` stays put while `auto_en` stays high, even if the new reference fails. It can switch again only after `auto_en` goes low and then high.
- R8: After any change of `mux_sel`, the missed-edge count restarts and is held at zero for BLANK_CYC (default 16) cycles. As a result `ref_fail` stays low for at least BLANK_CYC + FAIL_CYC cycles after a select change.
- R9: `bw_narrow` (1 = narrow loop bandwidth) equals `nbw_req` when `init_req` is low, and is forced to 0 (wide) whenever `init_req` is high. This path is combinational.
- R10: `hitless_trig` pulses high for exactly one cycle, one cycle after `lock_lost` rises, if `mux_sel` changed in that cycle or since the previous pulse. Otherwise a rise of `lock_lost` produces no pulse.
- R11: `lol_flag` is `lock_lost` delayed by one register. It is independent of `ref_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, independent of the references |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 2 | Raw reference clocks, index 0 and 1 |
| auto_en | input | 1 | 1 = automatic mode, 0 = manual mode |
| man_sel | input | 1 | Manual reference choice |
| init_req | input | 1 | Power-on initialization, forces wide bandwidth |
| nbw_req | input | 1 | Narrow bandwidth request |
| lock_lost | input | 1 | Loss-of-lock status from the loop (system-clock domain) |
| mux_sel | output | 1 | Reference multiplexer select |
| sel_ack | output | 1 | Reference actually in use |
| bw_narrow | output | 1 | Loop bandwidth control, 1 = narrow |
| ref_fail | output | 1 | Active reference declared missing |
| lol_flag | output | 1 | Registered loss-of-lock flag |
| hitless_trig | output | 1 | One-cycle hitless-switch trigger |

## Verification
If the one-shot permit is held in the wrong state, it shows up at the first failure of the active reference in automatic mode. Either `mux_sel` toggles a second time or it fails to toggle, so `sel_ack` differs from the model at the edge where `ref_fail` is high. A miscounted missed-edge or blanking counter moves the rise of `ref_fail`, and with it the switch, by one or more cycles within about 25 cycles of a select change or a reference stop. A stale hitless-pending state is seen as a missing or extra `hitless_trig` one cycle after the next rise of `lock_lost`.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  localparam int unsigned NUM_REF = 2;

  typedef enum logic {
    REF_0 = 1'b0,
    REF_1 = 1'b1
  } ref_id_e;

  function automatic ref_id_e other_ref(input ref_id_e r);
    return (r == REF_0) ? REF_1 : REF_0;
  endfunction
endpackage

// File: rtl/refsw_edge_sync.sv
module refsw_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], raw};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/refsw_miss_det.sv
module refsw_miss_det #(
  parameter int unsigned FAIL_CYC  = 8,
  parameter int unsigned BLANK_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  input  logic restart,
  output logic ref_fail
);
  localparam int unsigned MW = $clog2(FAIL_CYC + 1);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);
  localparam logic [MW-1:0] MISS_MAX  = MW'(FAIL_CYC);
  localparam logic [BW-1:0] BLANK_MAX = BW'(BLANK_CYC);

  logic [MW-1:0] miss_cnt;
  logic [BW-1:0] blank_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_cnt  <= '0;
      blank_cnt <= BLANK_MAX;
    end else if (restart) begin
      miss_cnt  <= '0;
      blank_cnt <= BLANK_MAX;
    end else if (blank_cnt != '0) begin
      miss_cnt  <= '0;
      blank_cnt <= blank_cnt - 1'b1;
    end else if (edge_seen) begin
      miss_cnt  <= '0;
    end else if (miss_cnt != MISS_MAX) begin
      miss_cnt  <= miss_cnt + 1'b1;
    end
  end

  assign ref_fail = (miss_cnt == MISS_MAX);

  // R8: a select change restarts the count
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (miss_cnt == '0));

  // R5: once failed, stays failed until an edge or a restart
  p_fail_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (ref_fail && !edge_seen && !restart && blank_cnt == '0) |=> ref_fail);
endmodule

// File: rtl/refsw_sel_fsm.sv
module refsw_sel_fsm
  import refsw_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    auto_en,
  input  logic    man_sel,
  input  logic    ref_fail,
  output ref_id_e sel,
  output logic    sel_chg
);
  logic    auto_q;
  logic    armed, armed_d;
  ref_id_e sel_d;

  always_comb begin
    sel_d   = sel;
    armed_d = armed;
    if (!auto_en) begin
      sel_d   = ref_id_e'(man_sel);
      armed_d = 1'b0;
    end else if (!auto_q) begin
      sel_d   = ref_id_e'(man_sel);
      armed_d = 1'b1;
    end else if (armed && ref_fail) begin
      sel_d   = other_ref(sel);
      armed_d = 1'b0;
    end
  end

  assign sel_chg = (sel_d != sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= REF_0;
      armed  <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      sel    <= sel_d;
      armed  <= armed_d;
      auto_q <= auto_en;
    end
  end

  // R2: manual mode follows the select pin
  p_manual_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> (sel == ref_id_e'($past(man_sel))));

  // R7: no further move once the permit is spent
  p_one_switch_r7: assert property (@(posedge clk) disable iff (rst)
    (auto_en && auto_q && !armed) |=> $stable(sel));

  // R6: armed auto mode with a failure always moves
  p_switch_on_fail_r6: assert property (@(posedge clk) disable iff (rst)
    (auto_en && auto_q && armed && ref_fail) |=> (sel != $past(sel)));
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int unsigned FAIL_CYC    = 8,
  parameter int unsigned BLANK_CYC   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REF-1:0] ref_clk,
  input  logic               auto_en,
  input  logic               man_sel,
  input  logic               init_req,
  input  logic               nbw_req,
  input  logic               lock_lost,
  output logic               mux_sel,
  output logic               sel_ack,
  output logic               bw_narrow,
  output logic               ref_fail,
  output logic               lol_flag,
  output logic               hitless_trig
);
  logic [NUM_REF-1:0] rise;
  ref_id_e            sel;
  logic               sel_chg;
  logic               hs_pend;
  logic               lol_rise;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_sync
    refsw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .raw  (ref_clk[g]),
      .rise (rise[g])
    );
  end

  refsw_miss_det #(.FAIL_CYC(FAIL_CYC), .BLANK_CYC(BLANK_CYC)) u_miss (
    .clk       (clk),
    .rst       (rst),
    .edge_seen (rise[sel]),
    .restart   (sel_chg),
    .ref_fail  (ref_fail)
  );

  refsw_sel_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (auto_en),
    .man_sel  (man_sel),
    .ref_fail (ref_fail),
    .sel      (sel),
    .sel_chg  (sel_chg)
  );

  assign mux_sel   = sel;
  assign sel_ack   = sel;
  assign bw_narrow = nbw_req & ~init_req;
  assign lol_rise  = lock_lost & ~lol_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      lol_flag     <= 1'b0;
      hs_pend      <= 1'b0;
      hitless_trig <= 1'b0;
    end else begin
      lol_flag     <= lock_lost;
      hitless_trig <= lol_rise & (hs_pend | sel_chg);
      hs_pend      <= lol_rise ? 1'b0 : (hs_pend | sel_chg);
    end
  end

  // R10: trigger is a single-cycle pulse
  p_trig_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    hitless_trig |=> !hitless_trig);

  // R11: registered loss-of-lock flag
  p_lol_tracks_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lol_flag == $past(lock_lost)));
endmodule

// File: tb/refsw_ctrl_test.sv
`timescale 1ns/1ps
module refsw_ctrl_test;
  localparam int FAIL  = 8;
  localparam int BLANK = 16;

  logic clk = 0;
  logic rst = 1;
  logic [1:0] ref_clk = 2'b00;
  logic auto_en = 0, man_sel = 0, init_req = 0, nbw_req = 0, lock_lost = 0;
  logic mux_sel, sel_ack, bw_narrow, ref_fail, lol_flag, hitless_trig;

  int tests = 0, fails = 0;
  bit done = 0;
  bit run0 = 1, run1 = 1;
  int rc = 0;

  always #2 clk = ~clk;

  refsw_ctrl #(.FAIL_CYC(FAIL), .BLANK_CYC(BLANK), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .auto_en(auto_en), .man_sel(man_sel),
    .init_req(init_req), .nbw_req(nbw_req), .lock_lost(lock_lost),
    .mux_sel(mux_sel), .sel_ack(sel_ack), .bw_narrow(bw_narrow),
    .ref_fail(ref_fail), .lol_flag(lol_flag), .hitless_trig(hitless_trig)
  );

  // reference clocks: period of four system cycles when running
  always @(negedge clk) begin
    rc <= rc + 1;
    ref_clk[0] <= run0 ? rc[1] : 1'b0;
    ref_clk[1] <= run1 ? rc[1] : 1'b0;
  end

  // behavioural model
  int m_sel, m_arm, m_seen, m_miss, m_blank, m_lol, m_pend, m_hs;
  int h0[$], h1[$];
  initial begin
    h0 = '{0, 0, 0};
    h1 = '{0, 0, 0};
  end

  always @(posedge clk) begin
    int nsel, narm, chg, rise_act, rl, failed;
    if (rst) begin
      m_sel = 0; m_arm = 0; m_seen = 0; m_miss = 0; m_blank = BLANK;
      m_lol = 0; m_pend = 0; m_hs = 0;
      h0 = '{0, 0, 0}; h1 = '{0, 0, 0};
    end else begin
      rise_act = (m_sel == 0) ? (h0[1] == 1 && h0[2] == 0) : (h1[1] == 1 && h1[2] == 0);
      failed = (m_miss == FAIL);
      nsel = m_sel; narm = m_arm;
      if (!auto_en) begin nsel = man_sel; narm = 0; end
      else if (!m_seen) begin nsel = man_sel; narm = 1; end
      else if (m_arm && failed) begin nsel = 1 - m_sel; narm = 0; end
      chg = (nsel != m_sel);
      if (chg) begin m_miss = 0; m_blank = BLANK; end
      else if (m_blank > 0) begin m_miss = 0; m_blank--; end
      else if (rise_act) m_miss = 0;
      else if (m_miss < FAIL) m_miss++;
      rl = lock_lost && !m_lol;
      m_hs = rl && (m_pend || chg);
      m_pend = rl ? 0 : (m_pend || chg);
      m_lol = lock_lost;
      m_seen = auto_en;
      m_sel = nsel; m_arm = narm;
      void'(h0.pop_back()); h0.push_front(ref_clk[0]);
      void'(h1.pop_back()); h1.push_front(ref_clk[1]);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      check(mux_sel == m_sel, "R2/R6 mux_sel", mux_sel, m_sel);
      check(sel_ack == m_sel, "R4 sel_ack", sel_ack, m_sel);
      check(bw_narrow == (nbw_req && !init_req), "R9 bw_narrow", bw_narrow, nbw_req && !init_req);
      check(ref_fail == (m_miss == FAIL), "R5 ref_fail", ref_fail, m_miss == FAIL);
      check(lol_flag == m_lol, "R11 lol_flag", lol_flag, m_lol);
      check(hitless_trig == m_hs, "R10 hitless_trig", hitless_trig, m_hs);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    cyc(4);
    @(posedge clk); #1;
    check(mux_sel == 0 && ref_fail == 0 && lol_flag == 0 && hitless_trig == 0,
          "R1 reset state", {mux_sel, ref_fail, lol_flag, hitless_trig}, 0);
    @(negedge clk); rst = 0;
    cyc(3);
    // R1: no switch before auto mode is seen: stop ref0 in manual mode
    run0 = 0; cyc(40);
    check(mux_sel == 0, "R1 no auto switch unarmed", mux_sel, 0);
    run0 = 1; cyc(10);
    // R2: manual selection
    man_sel = 1; cyc(2);
    check(mux_sel == 1, "R2 manual select 1", mux_sel, 1);
    man_sel = 0; cyc(2);
    check(mux_sel == 0, "R2 manual select 0", mux_sel, 0);
    // R9: bandwidth
    nbw_req = 1; init_req = 1; #1;
    check(bw_narrow == 0, "R9 init forces wide", bw_narrow, 0);
    init_req = 0; #1;
    check(bw_narrow == 1, "R9 narrow request", bw_narrow, 1);
    cyc(30);
    // R3: entering auto loads man_sel
    man_sel = 1; auto_en = 1; cyc(30);
    check(mux_sel == 1, "R3 auto entry loads select", mux_sel, 1);
    // R6: ref1 stops -> switch to 0
    run1 = 0; cyc(30);
    check(mux_sel == 0, "R6 auto switch", mux_sel, 0);
    check(sel_ack == 0 && man_sel == 1, "R4 ack differs from manual pin", sel_ack, 0);
    // R10: lock loss after reselection -> pulse
    lock_lost = 1;
    @(posedge clk); #1;
    check(hitless_trig == 1, "R10 trigger after reselection", hitless_trig, 1);
    check(lol_flag == 1, "R11 lol flag set", lol_flag, 1);
    @(posedge clk); #1;
    check(hitless_trig == 0, "R10 single cycle", hitless_trig, 0);
    @(negedge clk); lock_lost = 0; cyc(3);
    lock_lost = 1;
    @(posedge clk); #1;
    check(hitless_trig == 0, "R10 no trigger without reselection", hitless_trig, 1'b0);
    @(negedge clk); lock_lost = 0;
    // R7: new reference fails too -> stays
    run0 = 0; cyc(40);
    check(mux_sel == 0, "R7 non-revertive", mux_sel, 0);
    check(ref_fail == 1, "R5 failure flagged", ref_fail, 1);
    run0 = 1; cyc(10);
    check(ref_fail == 0, "R5 failure clears on edges", ref_fail, 0);
    // R8: manual change onto a dead reference: blanked
    auto_en = 0; man_sel = 1; cyc(12);
    check(ref_fail == 0, "R8 blanking after change", ref_fail, 0);
    cyc(20);
    check(ref_fail == 1, "R5/R8 fail after blank", ref_fail, 1);
    // R7: re-arm permits another switch
    run1 = 1; man_sel = 0; cyc(3);
    auto_en = 1; cyc(30);
    run0 = 0; cyc(35);
    check(mux_sel == 1, "R7 re-armed switch", mux_sel, 1);
    run0 = 1; cyc(10);
    finish_up();
  end
endmodule